// File: doc/BRIEF.md
# Multi-format serial PCM receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, word clock, serial data) and hands out one left/right pair of 24-bit two's-complement samples per frame, marked by a single-cycle valid strobe. It runs from a system clock that is much faster than the bit clock. The bit clock, word clock and data are brought into the system clock domain, and the block acts on each active bit-clock edge it detects there.

Two static configuration fields set its behaviour. One picks one of four framing conventions: word-clock-high-is-left with no delay, the one-bit-delayed convention with word clock low for left, fixed-offset right-aligned words, and a pulsed-sync mode that samples on the falling bit-clock edge. The other sets the word length used by the right-aligned mode. Words longer than 24 bits are cut to their first 24 bits. Shorter words are placed at the top of the sample, with zeros below.

Top module: `serial_pcm_rx`

## Requirements
- R1: After reset, pcm_valid is 0 and both sample outputs are 0. The all-zero configuration (cfg_format 00, cfg_wordlen 00) selects the delayed-MSB format with 24-bit words.
- R2: With cfg_format 01, word clock high marks the left channel. The MSB is taken on the first rising bit-clock edge that sees the new word-clock level, and later bits on the rising edges that follow.
- R3: With cfg_format 00, word clock low marks the left channel. The MSB is taken on the second rising edge of the channel, one bit period after the word-clock change.
- R4: With cfg_format 10, the first rising edge at a new word-clock level is position 0. Capture starts at position 32 minus L and takes exactly L bits, where L is 24, 20, 18 or 16 for cfg_wordlen 00, 01, 10 or 11 (start positions 8, 12, 14, 16). The L bits are placed at the top of the sample and the rest is zero.
- R5: With cfg_format 11, bits are taken on falling bit-clock edges. A word clock sampled high on one or more edges marks a channel start, and the MSB is the first falling edge after that with word clock low. The first such pulse after reset opens the left channel, and later pulses alternate right, left, and so on.
- R6: In formats 00, 01 and 11, bits after the 24th of a channel are dropped, and the sample holds the first 24 bits received.
- R7: A channel that ends after fewer than 24 bits gives those bits at the top of the sample with zeros below. This includes the packed layout of 16 bit clocks per channel in format 01.
- R8: A sample pair is output when the right word ends, at the next channel boundary. pcm_left and pcm_right change together in the cycle in which pcm_valid is 1 for one clock, and keep their values otherwise.
- R9: A right word that ends with no left word received since the last output produces no pcm_valid.
- R10: pcm_valid is 1 in the clock cycle after the third rising clk edge that follows the bit-clock edge that closes the right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Word clock / frame sync |
| sdata_i | input | 1 | Serial data, MSB first |
| cfg_format | input | 2 | 00 delayed-MSB, 01 left-aligned, 10 right-aligned, 11 pulsed sync |
| cfg_wordlen | input | 2 | Right-aligned word length: 00=24, 01=20, 10=18, 11=16 |
| pcm_left | output | 24 | Left sample, two's complement |
| pcm_right | output | 24 | Right sample, two's complement |
| pcm_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The bench records the clock count at each active bit-clock edge it drives. When pcm_valid appears, it requires that exactly three clock cycles have passed since the most recent such edge, which covers the two-stage input synchronizer and the output register. All outputs are sampled on the falling clk edge. Stimulus changes on the non-active bit-clock edge, so data is steady for a full half period around the edge the block uses. Each test appends one flushing boundary so that the last right word is delivered, then compares the number of strobes against the number of frames sent.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    localparam int SMP_W     = 24;
    localparam int SLOT_CLKS = 32;
    localparam int POS_W     = 6;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    // One active bit-clock edge, as seen by the word assembler.
    typedef struct packed {
        logic bnd;        // a channel boundary falls on this edge
        logic had_chan;   // a channel was open before this edge
        logic old_right;  // that channel was the right one
        logic cap;        // this edge's bit belongs to the word
        logic bit_val;    // the sampled data bit
    } slot_ev_t;

    function automatic logic [POS_W-1:0] len_bits(input logic [1:0] code);
        case (code)
            2'b00:   return POS_W'(24);
            2'b01:   return POS_W'(20);
            2'b10:   return POS_W'(18);
            default: return POS_W'(16);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] rj_first(input logic [1:0] code);
        return POS_W'(SLOT_CLKS) - len_bits(code);
    endfunction

    function automatic logic [SMP_W-1:0] pad_mask(input logic [1:0] code);
        logic [SMP_W-1:0] m;
        m = '0;
        for (int i = 0; i < SMP_W; i++)
            if (i < SMP_W - int'(len_bits(code))) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/audrx_sync.sv
module audrx_sync #(
    parameter int STAGES = 2,
    parameter int LANES  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] raw_i,      // lane 0 is the bit clock
    input  logic             fall_mode,
    output logic             fire,
    output logic [LANES-2:0] lvl_o
);
    logic [LANES-1:0] stg [STAGES];
    logic             bclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            bclk_d <= 1'b0;
        end else begin
            stg[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            bclk_d <= stg[STAGES-1][0];
        end
    end

    assign fire  = fall_mode ? (bclk_d & ~stg[STAGES-1][0])
                             : (stg[STAGES-1][0] & ~bclk_d);
    assign lvl_o = stg[STAGES-1][LANES-1:1];
endmodule

// File: rtl/audrx_framer.sv
module audrx_framer
    import audrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       wclk_s,
    input  logic       data_s,
    input  logic [1:0] fmt,
    input  logic [1:0] len_code,
    output slot_ev_t   ev
);
    fmt_e             fmt_q;
    logic             w_prev, started, in_right;
    logic [POS_W-1:0] pos;
    logic             bnd, new_right, in_win;
    logic [POS_W-1:0] pos_now;

    assign fmt_q = fmt_e'(fmt);

    always_comb begin
        bnd     = (fmt_q == FMT_DSP) ? (wclk_s & ~w_prev) : (wclk_s ^ w_prev);
        pos_now = bnd ? '0 : pos;
        case (fmt_q)
            FMT_DSP: new_right = started & ~in_right;
            FMT_I2S: new_right = wclk_s;
            default: new_right = ~wclk_s;
        endcase
        case (fmt_q)
            FMT_LJ:  in_win = 1'b1;
            FMT_I2S: in_win = (pos_now != '0);
            FMT_RJ:  in_win = (pos_now >= rj_first(len_code));
            default: in_win = ~wclk_s;
        endcase
        ev.bnd      = fire & bnd;
        ev.had_chan = started;
        ev.old_right = in_right;
        ev.cap      = fire & (started | bnd) & in_win;
        ev.bit_val  = data_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_prev   <= 1'b0;
            started  <= 1'b0;
            in_right <= 1'b0;
            pos      <= '0;
        end else if (fire) begin
            w_prev <= wclk_s;
            if (bnd) begin
                pos      <= POS_W'(1);
                started  <= 1'b1;
                in_right <= new_right;
            end else if (pos != '1) begin
                pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/audrx_shifter.sv
module audrx_shifter
    import audrx_pkg::*;
#(
    parameter int DW = SMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_ev_t      ev,
    input  logic [1:0]    fmt,
    input  logic [1:0]    len_code,
    output logic          cm_valid,
    output logic          cm_right,
    output logic [DW-1:0] cm_word
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] acc;
    logic [CW-1:0] cnt, lim;

    assign lim      = (fmt_e'(fmt) == FMT_RJ) ? CW'(len_bits(len_code)) : CW'(DW);
    assign cm_valid = ev.bnd & ev.had_chan & (cnt != '0);
    assign cm_right = ev.old_right;
    assign cm_word  = acc << (CW'(DW) - cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            cnt <= '0;
        end else if (ev.bnd) begin
            acc <= {{(DW-1){1'b0}}, ev.bit_val & ev.cap};
            cnt <= ev.cap ? CW'(1) : '0;
        end else if (ev.cap && (cnt < lim)) begin
            acc <= {acc[DW-2:0], ev.bit_val};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/audrx_outreg.sv
module audrx_outreg #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cm_valid,
    input  logic          cm_right,
    input  logic [DW-1:0] cm_word,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right,
    output logic          out_valid
);
    logic [DW-1:0] pend_l;
    logic          have_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_l    <= '0;
            have_l    <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (cm_valid) begin
                if (!cm_right) begin
                    pend_l <= cm_word;
                    have_l <= 1'b1;
                end else if (have_l) begin
                    out_left  <= pend_l;
                    out_right <= cm_word;
                    out_valid <= 1'b1;
                    have_l    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
    import audrx_pkg::*;
#(
    parameter int SAMPLE_W = SMP_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_i,
    input  logic                fsync_i,
    input  logic                sdata_i,
    input  logic [1:0]          cfg_format,
    input  logic [1:0]          cfg_wordlen,
    output logic [SAMPLE_W-1:0] pcm_left,
    output logic [SAMPLE_W-1:0] pcm_right,
    output logic                pcm_valid
);
    logic                use_fall, fire;
    logic [1:0]          lvl;
    slot_ev_t            ev;
    logic                cm_valid, cm_right;
    logic [SAMPLE_W-1:0] cm_word;

    assign use_fall = (fmt_e'(cfg_format) == FMT_DSP);

    audrx_sync #(.STAGES(2), .LANES(3)) u_sync (
        .clk(clk), .rst(rst),
        .raw_i({sdata_i, fsync_i, sclk_i}),
        .fall_mode(use_fall),
        .fire(fire), .lvl_o(lvl)
    );

    audrx_framer u_framer (
        .clk(clk), .rst(rst), .fire(fire),
        .wclk_s(lvl[0]), .data_s(lvl[1]),
        .fmt(cfg_format), .len_code(cfg_wordlen),
        .ev(ev)
    );

    audrx_shifter #(.DW(SAMPLE_W)) u_shift (
        .clk(clk), .rst(rst), .ev(ev),
        .fmt(cfg_format), .len_code(cfg_wordlen),
        .cm_valid(cm_valid), .cm_right(cm_right), .cm_word(cm_word)
    );

    audrx_outreg #(.DW(SAMPLE_W)) u_out (
        .clk(clk), .rst(rst),
        .cm_valid(cm_valid), .cm_right(cm_right), .cm_word(cm_word),
        .out_left(pcm_left), .out_right(pcm_right), .out_valid(pcm_valid)
    );
endmodule

// File: rtl/serial_pcm_rx_chk.sv
module serial_pcm_rx_chk
    import audrx_pkg::*;
#(
    parameter int DW = SMP_W
) (
    input logic          clk,
    input logic          rst,
    input logic          fire,
    input logic          cm_valid,
    input logic          pcm_valid,
    input logic [1:0]    cfg_format,
    input logic [1:0]    cfg_wordlen,
    input logic [DW-1:0] pcm_left,
    input logic [DW-1:0] pcm_right
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right)));

    a_r4_rj_zero_pad: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && fmt_e'(cfg_format) == FMT_RJ) |->
        (((pcm_left | pcm_right) & DW'(pad_mask(cfg_wordlen))) == '0));

    a_r10_after_edge: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> $past(fire));

    a_r9_from_commit: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> $past(cm_valid));
endmodule

bind serial_pcm_rx serial_pcm_rx_chk #(.DW(SAMPLE_W)) u_chk (
    .clk(clk), .rst(rst), .fire(fire), .cm_valid(cm_valid),
    .pcm_valid(pcm_valid), .cfg_format(cfg_format), .cfg_wordlen(cfg_wordlen),
    .pcm_left(pcm_left), .pcm_right(pcm_right)
);

// File: tb/sim_serial_pcm_rx.sv
module sim_serial_pcm_rx;
    localparam logic [1:0] F_I2S = 2'b00, F_LJ = 2'b01, F_RJ = 2'b10, F_DSP = 2'b11;
    localparam int HB = 4;
    localparam int WDOG = 190000;

    logic clk = 1'b0, rst = 1'b1;
    logic bclk = 1'b0, wclk = 1'b0, sd = 1'b0;
    logic [1:0] fmt = 2'b00, wlen = 2'b00;
    logic [23:0] pcm_left, pcm_right;
    logic pcm_valid;

    int checks = 0, fails = 0;
    int cyc = 0, last_edge = 0;
    logic [23:0] exp_l [64];
    logic [23:0] exp_r [64];
    int wr = 0, rd = 0;
    logic pv = 1'b0;

    always #10 clk = ~clk;

    serial_pcm_rx u0 (
        .clk(clk), .rst(rst), .sclk_i(bclk), .fsync_i(wclk), .sdata_i(sd),
        .cfg_format(fmt), .cfg_wordlen(wlen),
        .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic ok, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Output monitor: R8 pair, R9 no stray strobe, R10 latency
    always @(negedge clk) begin
        if (!rst && pcm_valid) begin
            chk("R8", !pv, "valid longer than one cycle", 1, 0);
            chk("R10", (cyc - last_edge) == 3, "valid latency", cyc - last_edge, 3);
            if (rd >= wr) begin
                chk("R9", 1'b0, "unexpected valid", rd, wr);
            end else begin
                chk("R2", pcm_left == exp_l[rd], "left sample", pcm_left, exp_l[rd]);
                chk("R2", pcm_right == exp_r[rd], "right sample", pcm_right, exp_r[rd]);
                rd++;
            end
        end
        pv <= rst ? 1'b0 : pcm_valid;
    end

    function automatic int lenbits(input logic [1:0] c);
        case (c) 2'b00: return 24; 2'b01: return 20; 2'b10: return 18; default: return 16; endcase
    endfunction

    function automatic logic [23:0] expect_word(input logic [31:0] word, input int nb);
        logic [63:0] v;
        int L;
        v = {32'd0, word} & ((64'd1 << nb) - 64'd1);
        if (fmt == F_RJ) begin
            L = lenbits(wlen);
            v = v & ((64'd1 << L) - 64'd1);
            return v[23:0] << (24 - L);
        end
        if (nb > 24) return 24'(v >> (nb - 24));
        return v[23:0] << (24 - nb);
    endfunction

    task automatic put_bit(input logic w, input logic d);
        @(negedge clk);
        bclk = (fmt == F_DSP);
        wclk = w;
        sd   = d;
        repeat (HB) @(negedge clk);
        bclk = (fmt != F_DSP);
        last_edge = cyc;
        repeat (HB - 1) @(negedge clk);
    endtask

    task automatic send_half(input logic lvl, input int slot, input int nb,
                             input logic [31:0] word, input int pw);
        for (int p = 0; p < slot; p++) begin
            int q;
            logic d, w;
            case (fmt)
                F_LJ:    q = p;
                F_I2S:   q = p - 1;
                F_RJ:    q = p - (slot - nb);
                default: q = p - pw;
            endcase
            d = (q >= 0 && q < nb) ? word[nb-1-q] : 1'b0;
            w = (fmt == F_DSP) ? (p < pw) : lvl;
            put_bit(w, d);
        end
    endtask

    task automatic send_frame(input int slot, input int nb, input logic [31:0] l,
                              input logic [31:0] r, input int pw);
        logic lv;
        lv = (fmt == F_I2S) ? 1'b0 : 1'b1;
        exp_l[wr] = expect_word(l, nb);
        exp_r[wr] = expect_word(r, nb);
        wr++;
        send_half(lv, slot, nb, l, pw);
        send_half(~lv, slot, nb, r, pw);
    endtask

    task automatic finish_test(input string req);
        logic lv;
        lv = (fmt == F_I2S) ? 1'b0 : 1'b1;
        send_half(lv, 4, 0, 32'd0, 1);
        repeat (8) @(negedge clk);
        chk(req, rd == wr, "strobe count", rd, wr);
        chk("R8", pcm_left == exp_l[wr-1] && pcm_right == exp_r[wr-1],
            "outputs held after strobe", {pcm_left, pcm_right}, {exp_l[wr-1], exp_r[wr-1]});
    endtask

    task automatic start_test(input logic [1:0] f, input logic [1:0] l);
        @(negedge clk);
        rst = 1'b1; bclk = 1'b0; sd = 1'b0; fmt = f; wlen = l;
        wclk = 1'b0;
        wr = 0; rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // idle bits at the right-channel level: an orphan right word in I2S (R9)
        for (int i = 0; i < 3; i++) put_bit((f == F_I2S), 1'b1);
        repeat (6) @(negedge clk);
        chk("R9", !pcm_valid && rd == 0, "strobe from idle bits", rd, 0);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", pcm_valid == 1'b0, "valid after reset", pcm_valid, 0);
        chk("R1", pcm_left == 0 && pcm_right == 0, "samples after reset",
            {pcm_left, pcm_right}, 0);

        // R3 / R1: zero configuration, walking one over every bit position
        start_test(F_I2S, 2'b00);
        for (int k = 0; k < 24; k++)
            send_frame(32, 24, 32'd1 << k, ~(32'd1 << k) & 32'hFF_FFFF, 1);
        finish_test("R3");

        // R2: left-aligned, mixed patterns
        start_test(F_LJ, 2'b00);
        for (int k = 0; k < 4; k++)
            send_frame(32, 24, (32'h00A53C96 * (k + 1)) & 32'hFFFFFF,
                       (32'h007E1D2B ^ (k * 32'h1357B)) & 32'hFFFFFF, 1);
        finish_test("R2");

        // R6: oversized words are truncated to their first 24 bits
        start_test(F_LJ, 2'b00);
        send_frame(32, 28, 32'h0ABCDEF5, 32'h08000001, 1);
        send_frame(32, 28, 32'h0FFFFFFF, 32'h01234567, 1);
        finish_test("R6");
        start_test(F_I2S, 2'b00);
        send_frame(32, 30, 32'h2AAAAAAA, 32'h15555555, 1);
        finish_test("R6");

        // R7: packed layout, 16 clocks per channel
        start_test(F_LJ, 2'b00);
        for (int k = 0; k < 3; k++)
            send_frame(16, 16, 32'h8001 + k * 32'h1111, 32'h7FFE - k * 32'h0202, 1);
        finish_test("R7");

        // R4: right-aligned, each word-length code
        for (int c = 0; c < 4; c++) begin
            int L;
            start_test(F_RJ, 2'(c));
            L = lenbits(2'(c));
            for (int k = 0; k < 3; k++)
                send_frame(32, L, (32'hC35A96F1 >> k) & ((32'd1 << L) - 1),
                           (32'h5F0A3E7D << k) & ((32'd1 << L) - 1), 1);
            finish_test("R4");
        end
        // R4: offset is fixed, so a 24-bit word read as 20 bits keeps its low 20
        start_test(F_RJ, 2'b01);
        send_frame(32, 24, 32'hFEDCBA, 32'h9ABCDE, 1);
        finish_test("R4");

        // R5: pulsed sync on falling edges, one- and two-bit pulses
        start_test(F_DSP, 2'b00);
        for (int k = 0; k < 3; k++)
            send_frame(32, 24, 32'h800000 >> k, 32'h00F0F0 << k, 1);
        finish_test("R5");
        start_test(F_DSP, 2'b00);
        send_frame(32, 16, 32'hBEEF, 32'h1234, 2);
        send_frame(32, 16, 32'h8000, 32'h0001, 2);
        finish_test("R5");
        // R6 in pulsed mode
        start_test(F_DSP, 2'b00);
        send_frame(32, 30, 32'h3FFFFFC1, 32'h20000003, 1);
        finish_test("R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule